// File: doc/BRIEF.md
# CRT Controller CPU Register Port

This block is the processor side of a CRT timing controller. It watches an I/O request (an active-low chip enable, two operation-select address bits and separate read and write strobes) and turns it into one of four operations. It can latch a register index, store a byte into the indexed timing register, return a status byte, or return one of the readable address registers. The sixteen programmable timing registers are presented in parallel to the timing generator, which sits outside this block.

Two registers at indices 16 and 17 hold a light-pen address. They capture the running memory address whenever the light-pen strobe is high, and the processor can only read them. A flag in the status byte reports a pending capture, and reading the low capture register clears it. The data bus is split into an input, an output and an output-enable. The block raises the enable only in a cycle where it actually supplies data.

All accesses are level-sensitive. While a qualifying strobe is held, the operation takes effect at every rising clock edge, and readback is combinational in the same cycle. There is no streaming data path, so every pin is a plain control or data pin and none carries valid/ready flow control.

Top module: `crtc_cpu_port`

## Requirements
- R1: No operation takes place while `io_sel_n` is 1, or while both strobes are 1. Registers and the index keep their values and `doe` stays 0.
- R2: With `addr_op`=00 and `io_wr_n`=0, the index latch loads `din[4:0]` at the next edge. `din[7:5]` are discarded.
- R3: With `addr_op`=01 and either strobe low, `din` is stored into the indexed register (index 0..15) at the next edge. `doe` stays 0 in that cycle, even under a read strobe.
- R4: A store to an index from 16 to 31 changes no register.
- R5: Registers 12 and 14 keep only bits 5:0, and bits 7:6 read as 0.
- R6: With `addr_op`=11 and `io_rd_n`=0 and index 12..17, `doe`=1 and `dout` is that register's value in the same cycle.
- R7: A register read at index 0..11 or 18..31 leaves `doe`=0.
- R8: With `addr_op`=10 and `io_rd_n`=0, `doe`=1 and `dout` = {`upd_ready`, light-pen flag, `vblank`, 00000}.
- R9: While `lpen_strobe` is 1 at an edge, register 16 takes {00, `cur_ma[13:8]`}, register 17 takes `cur_ma[7:0]`, and the light-pen flag becomes 1.
- R10: A read of register 17 clears the light-pen flag at the next edge, unless `lpen_strobe` is 1 at that edge, in which case the flag stays 1.
- R11: After reset, registers 0..15 are 3F 28 2E 8E 26 00 19 1E 00 07 00 00 30 00 00 00 (hex), the index is 0, and the light-pen registers and flag are 0.
- R12: A read strobe on the select port (`addr_op`=00) leaves the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel_n | input | 1 | Active-low block enable from the address decoder |
| addr_op | input | 2 | Operation select: 00 index, 01 store, 10 status, 11 register read |
| io_rd_n | input | 1 | Active-low I/O read strobe |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| din | input | 8 | Data bus input |
| dout | output | 8 | Data bus output, meaningful when doe is 1 |
| doe | output | 1 | Output enable for dout |
| upd_ready | input | 1 | Update-ready flag from the timing generator |
| vblank | input | 1 | Vertical blanking flag from the timing generator |
| lpen_strobe | input | 1 | Light-pen capture strobe |
| cur_ma | input | 14 | Current memory address from the timing generator |
| timing_regs | output | 16x8 | Registers 0..15, entry i is register i |

## Verification
Every cycle, the in-line assertions check that the bus stays undriven while the block is deselected or the store port is addressed. They check that the low status bits stay zero, that light-pen capture and its clear behave as described, and that stores aimed past index 15 leave the bank untouched. They also check that a read strobe on the select port cannot move the index and that the narrow address registers keep bits 7:6 at zero. The bench's scenarios are needed to show the reset image and the masking of the upper index bits. They also show that a read strobe on the store port really writes, and that a capture in the same cycle as a clearing read wins. Finally, they cover the long random mix of indices, operations and strobes against a reference model.

// File: rtl/crtc_port_pkg.sv
package crtc_port_pkg;
  localparam int CRTC_DW   = 8;
  localparam int CRTC_IDXW = 5;
  localparam int CRTC_NRW  = 16;
  localparam int CRTC_MAW  = 14;
  localparam int CRTC_FIRST_RD = 12;

  typedef enum logic [1:0] {
    OP_SELECT = 2'b00,
    OP_STORE  = 2'b01,
    OP_STATUS = 2'b10,
    OP_READ   = 2'b11
  } port_op_e;

  // bits kept by each programmable register
  function automatic logic [CRTC_DW-1:0] reg_keep_mask(input int i);
    return (i == 12 || i == 14) ? 8'h3F : 8'hFF;
  endfunction

  // power-up image: 64-char lines, 39 rows of 8 scan lines, 50 Hz
  function automatic logic [CRTC_DW-1:0] reg_reset_val(input int i);
    case (i)
      0:  return 8'h3F;
      1:  return 8'h28;
      2:  return 8'h2E;
      3:  return 8'h8E;
      4:  return 8'h26;
      6:  return 8'h19;
      7:  return 8'h1E;
      9:  return 8'h07;
      12: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/crtc_bus_decode.sv
module crtc_bus_decode
  import crtc_port_pkg::*;
#(
  parameter int IDXW = CRTC_IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_sel_n,
  input  logic [1:0]      addr_op,
  input  logic            io_rd_n,
  input  logic            io_wr_n,
  input  logic [IDXW-1:0] din_low,
  output logic            sel_load,
  output logic            reg_store,
  output logic            stat_rd,
  output logic            reg_rd,
  output logic [IDXW-1:0] idx
);
  logic     rd_act, wr_act;
  port_op_e op;

  assign op     = port_op_e'(addr_op);
  assign rd_act = !io_sel_n && !io_rd_n;
  assign wr_act = !io_sel_n && !io_wr_n;

  always_comb begin
    sel_load  = 1'b0;
    reg_store = 1'b0;
    stat_rd   = 1'b0;
    reg_rd    = 1'b0;
    unique case (op)
      OP_SELECT: sel_load  = wr_act;
      OP_STORE:  reg_store = wr_act || rd_act;   // direction is not looked at
      OP_STATUS: stat_rd   = rd_act;
      OP_READ:   reg_rd    = rd_act;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        idx <= '0;
    else if (sel_load) idx <= din_low;
  end

  AST_SELECT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_sel_n && addr_op == 2'b00 && io_wr_n) |=> $stable(idx))
    else $error("index moved without write strobe"); // R12
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
  import crtc_port_pkg::*;
#(
  parameter int DW   = CRTC_DW,
  parameter int IDXW = CRTC_IDXW,
  parameter int NRW  = CRTC_NRW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDXW-1:0]         idx,
  input  logic [DW-1:0]           din,
  output logic [NRW-1:0][DW-1:0]  regs
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NRW - 1);

  for (genvar i = 0; i < NRW; i++) begin : g_reg
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(i);
    localparam logic [DW-1:0]   KEEP   = reg_keep_mask(i);
    localparam logic [DW-1:0]   INIT   = reg_reset_val(i);
    always_ff @(posedge clk) begin
      if (!rst_n)                     regs[i] <= INIT & KEEP;
      else if (we && idx == MY_IDX)   regs[i] <= din & KEEP;
    end
  end

  AST_RO_STORE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx > LAST_IDX) |=> $stable(regs))
    else $error("store beyond bank altered it"); // R4

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[12][7:6] == 2'b00 && regs[14][7:6] == 2'b00))
    else $error("narrow register grew upper bits"); // R5

  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == '0) |=> regs[0] == $past(din))
    else $error("store to register 0 lost"); // R3
endmodule

// File: rtl/crtc_lpen_capture.sv
module crtc_lpen_capture
  import crtc_port_pkg::*;
#(
  parameter int DW  = CRTC_DW,
  parameter int MAW = CRTC_MAW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic [MAW-1:0] ma,
  input  logic           flag_clr,
  output logic [DW-1:0]  lp_hi,
  output logic [DW-1:0]  lp_lo,
  output logic           flag
);
  localparam int HIW = MAW - DW;
  logic [HIW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lp_lo <= '0;
      flag  <= 1'b0;
    end else if (strobe) begin
      hi_q  <= ma[MAW-1:DW];
      lp_lo <= ma[DW-1:0];
      flag  <= 1'b1;
    end else if (flag_clr) begin
      flag  <= 1'b0;
    end
  end

  assign lp_hi = {{(DW-HIW){1'b0}}, hi_q};

  AST_LPEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> flag)
    else $error("capture did not raise flag"); // R9

  AST_LPEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !strobe) |=> !flag)
    else $error("flag survived read"); // R10
endmodule

// File: rtl/crtc_cpu_port.sv
module crtc_cpu_port
  import crtc_port_pkg::*;
#(
  parameter int DW   = CRTC_DW,
  parameter int IDXW = CRTC_IDXW,
  parameter int NRW  = CRTC_NRW,
  parameter int MAW  = CRTC_MAW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_sel_n,
  input  logic [1:0]             addr_op,
  input  logic                   io_rd_n,
  input  logic                   io_wr_n,
  input  logic [DW-1:0]          din,
  output logic [DW-1:0]          dout,
  output logic                   doe,
  input  logic                   upd_ready,
  input  logic                   vblank,
  input  logic                   lpen_strobe,
  input  logic [MAW-1:0]         cur_ma,
  output logic [NRW-1:0][DW-1:0] timing_regs
);
  localparam int              RIW     = $clog2(NRW);
  localparam logic [IDXW-1:0] RD_LO   = IDXW'(CRTC_FIRST_RD);
  localparam logic [IDXW-1:0] RD_HI   = IDXW'(NRW - 1);
  localparam logic [IDXW-1:0] LP_HI_I = IDXW'(NRW);
  localparam logic [IDXW-1:0] LP_LO_I = IDXW'(NRW + 1);

  logic            sel_load, reg_store, stat_rd, reg_rd;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   lp_hi, lp_lo;
  logic            lp_flag, lp_clr;
  logic            rd_hit;
  logic [DW-1:0]   rd_val;

  crtc_bus_decode #(.IDXW(IDXW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_sel_n (io_sel_n),
    .addr_op  (addr_op),
    .io_rd_n  (io_rd_n),
    .io_wr_n  (io_wr_n),
    .din_low  (din[IDXW-1:0]),
    .sel_load (sel_load),
    .reg_store(reg_store),
    .stat_rd  (stat_rd),
    .reg_rd   (reg_rd),
    .idx      (idx)
  );

  crtc_reg_bank #(.DW(DW), .IDXW(IDXW), .NRW(NRW)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_store),
    .idx  (idx),
    .din  (din),
    .regs (timing_regs)
  );

  assign lp_clr = reg_rd && (idx == LP_LO_I);

  crtc_lpen_capture #(.DW(DW), .MAW(MAW)) u_lpen (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (lpen_strobe),
    .ma      (cur_ma),
    .flag_clr(lp_clr),
    .lp_hi   (lp_hi),
    .lp_lo   (lp_lo),
    .flag    (lp_flag)
  );

  always_comb begin
    rd_hit = 1'b0;
    rd_val = '0;
    if (idx >= RD_LO && idx <= RD_HI) begin
      rd_hit = 1'b1;
      rd_val = timing_regs[idx[RIW-1:0]];
    end else if (idx == LP_HI_I) begin
      rd_hit = 1'b1;
      rd_val = lp_hi;
    end else if (idx == LP_LO_I) begin
      rd_hit = 1'b1;
      rd_val = lp_lo;
    end
  end

  always_comb begin
    doe  = 1'b0;
    dout = '0;
    if (stat_rd) begin
      doe  = 1'b1;
      dout = {upd_ready, lp_flag, vblank, {(DW-3){1'b0}}};
    end else if (reg_rd && rd_hit) begin
      doe  = 1'b1;
      dout = rd_val;
    end
  end

  AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    io_sel_n |-> !doe)
    else $error("bus driven while deselected"); // R1

  AST_STORE_PORT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_op == 2'b01) |-> !doe)
    else $error("bus driven on store port"); // R3

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_sel_n && !io_rd_n && addr_op == 2'b10) |-> (doe && dout[4:0] == 5'b0))
    else $error("status low bits not zero"); // R8
endmodule

// File: tb/crtc_cpu_port_test.sv
module crtc_cpu_port_test;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             io_sel_n = 1'b1;
  logic [1:0]       addr_op = 2'b00;
  logic             io_rd_n = 1'b1;
  logic             io_wr_n = 1'b1;
  logic [7:0]       din = 8'h00;
  logic [7:0]       dout;
  logic             doe;
  logic             upd_ready = 1'b0;
  logic             vblank = 1'b0;
  logic             lpen_strobe = 1'b0;
  logic [13:0]      cur_ma = 14'h0;
  logic [15:0][7:0] timing_regs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] m_regs [18];
  logic [4:0] m_idx;
  logic       m_flag;
  logic [7:0] last_dout;
  logic       last_doe;
  logic       g_upd = 1'b0, g_vb = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_cpu_port uut (
    .clk(clk), .rst_n(rst_n), .io_sel_n(io_sel_n), .addr_op(addr_op),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .din(din), .dout(dout), .doe(doe),
    .upd_ready(upd_ready), .vblank(vblank), .lpen_strobe(lpen_strobe),
    .cur_ma(cur_ma), .timing_regs(timing_regs)
  );

  // R11 reset image
  function automatic logic [7:0] exp_reset(input int i);
    case (i)
      0: return 8'h3F;  1: return 8'h28;  2: return 8'h2E;  3: return 8'h8E;
      4: return 8'h26;  6: return 8'h19;  7: return 8'h1E;  9: return 8'h07;
      12: return 8'h30;
      default: return 8'h00;
    endcase
  endfunction

  // R5 narrow registers
  function automatic logic [7:0] exp_mask(input int i);
    return (i == 12 || i == 14 || i == 16) ? 8'h3F : 8'hFF;
  endfunction

  function automatic string op_tag(input logic sel_n, input logic [1:0] op,
                                   input logic rd_n, input logic wr_n, input logic [4:0] ix);
    if (sel_n || (rd_n && wr_n)) return "R1";
    case (op)
      2'b00: return "R12";
      2'b01: return "R3";
      2'b10: return "R8";
      default: return (ix >= 12 && ix <= 17) ? "R6" : "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 18; i++) m_regs[i] = (i < 16) ? exp_reset(i) : 8'h00;
    m_idx  = 5'd0;
    m_flag = 1'b0;
  endtask

  task automatic step(input logic sel_n, input logic [1:0] op, input logic rd_n,
                      input logic wr_n, input logic [7:0] d, input logic lp,
                      input logic [13:0] ma);
    logic       e_oe;
    logic [7:0] e_do;
    logic       rd_act, wr_act;
    io_sel_n = sel_n; addr_op = op; io_rd_n = rd_n; io_wr_n = wr_n;
    din = d; lpen_strobe = lp; cur_ma = ma; upd_ready = g_upd; vblank = g_vb;
    #1;
    for (int i = 0; i < 16; i++) chk("R3", timing_regs[i], m_regs[i]);
    rd_act = !sel_n && !rd_n;
    wr_act = !sel_n && !wr_n;
    e_oe = 1'b0; e_do = 8'h00;
    if (rd_act && op == 2'b10) begin
      e_oe = 1'b1; e_do = {g_upd, m_flag, g_vb, 5'b0};
    end else if (rd_act && op == 2'b11 && m_idx >= 12 && m_idx <= 17) begin
      e_oe = 1'b1; e_do = m_regs[m_idx];
    end
    chk(op_tag(sel_n, op, rd_n, wr_n, m_idx), {31'b0, doe}, {31'b0, e_oe});
    if (e_oe) chk(op_tag(sel_n, op, rd_n, wr_n, m_idx), {24'b0, dout}, {24'b0, e_do});
    last_dout = dout;
    last_doe  = doe;
    // model of next edge
    if (lp) begin
      m_regs[16] = {2'b00, ma[13:8]};
      m_regs[17] = ma[7:0];
      m_flag = 1'b1;
    end else if (rd_act && op == 2'b11 && m_idx == 5'd17) begin
      m_flag = 1'b0;
    end
    if ((rd_act || wr_act) && op == 2'b01 && m_idx < 16)
      m_regs[m_idx] = d & exp_mask(int'(m_idx));
    if (wr_act && op == 2'b00) m_idx = d[4:0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_sel(input logic [7:0] d);
    step(1'b0, 2'b00, 1'b1, 1'b0, d, 1'b0, 14'h0);
  endtask
  task automatic do_store(input logic [7:0] d, input logic via_rd);
    step(1'b0, 2'b01, !via_rd, via_rd, d, 1'b0, 14'h0);
  endtask
  task automatic do_read(input logic [1:0] op);
    step(1'b0, op, 1'b0, 1'b1, 8'h00, 1'b0, 14'h0);
  endtask
  task automatic idle();
    step(1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 1'b0, 14'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset image on the parallel outputs
    for (int i = 0; i < 16; i++) chk("R11", timing_regs[i], exp_reset(i));
    idle();

    // R2: upper data bits ignored by select, EC -> index 12
    do_sel(8'hEC);
    do_read(2'b11);
    chk("R2", {24'b0, last_dout}, 32'h30);
    chk("R6", {31'b0, last_doe}, 32'h1);

    // R3: read strobe on the store port still writes
    do_sel(8'd13);
    do_store(8'h55, 1'b1);
    chk("R3", {31'b0, last_doe}, 32'h0);
    do_read(2'b11);
    chk("R3", {24'b0, last_dout}, 32'h55);

    // R5: narrow register
    do_sel(8'd14);
    do_store(8'hFF, 1'b0);
    do_read(2'b11);
    chk("R5", {24'b0, last_dout}, 32'h3F);

    // R4: light-pen register not writable, unused index harmless
    do_sel(8'd16);
    do_store(8'hAA, 1'b0);
    do_read(2'b11);
    chk("R4", {24'b0, last_dout}, 32'h00);
    do_sel(8'd20);
    do_store(8'h12, 1'b0);
    idle();

    // R7: write-only register not driven
    do_sel(8'd5);
    do_read(2'b11);
    chk("R7", {31'b0, last_doe}, 32'h0);

    // R9: capture
    step(1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 1'b1, 14'h2ABC);
    do_read(2'b10);
    chk("R9", {24'b0, last_dout}, 32'h40);
    do_sel(8'd16);
    do_read(2'b11);
    chk("R9", {24'b0, last_dout}, 32'h2A);
    do_sel(8'd17);
    do_read(2'b11);
    chk("R9", {24'b0, last_dout}, 32'hBC);
    // R10: that read cleared the flag
    do_read(2'b10);
    chk("R10", {24'b0, last_dout}, 32'h00);
    // R10: capture in same cycle as clearing read keeps the flag
    step(1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 1'b1, 14'h0101);
    step(1'b0, 2'b11, 1'b0, 1'b1, 8'h00, 1'b1, 14'h0202);
    do_read(2'b10);
    chk("R10", {24'b0, last_dout}, 32'h40);
    do_read(2'b11);

    // R1: deselected store has no effect
    do_sel(8'd1);
    step(1'b1, 2'b01, 1'b1, 1'b0, 8'h77, 1'b0, 14'h0);
    chk("R1", {31'b0, last_doe}, 32'h0);
    idle();
    chk("R1", {24'b0, timing_regs[1]}, 32'h28);

    // R12: read strobe on select port keeps index
    do_sel(8'd15);
    step(1'b0, 2'b00, 1'b0, 1'b1, 8'h02, 1'b0, 14'h0);
    do_store(8'h11, 1'b0);
    do_read(2'b11);
    chk("R12", {24'b0, last_dout}, 32'h11);
    chk("R12", {24'b0, timing_regs[2]}, 32'h2E);

    // R8: status flags
    g_upd = 1'b1; g_vb = 1'b1;
    do_read(2'b10);
    chk("R8", {24'b0, last_dout}, 32'hA0);
    g_upd = 1'b0; g_vb = 1'b0;

    // random mix checked against the model
    for (int n = 0; n < 3000; n++) begin
      logic       s_n;
      logic [1:0] op;
      logic [1:0] dir;
      g_upd = 1'($urandom);
      g_vb  = 1'($urandom);
      s_n   = ($urandom % 8) == 0;
      op    = 2'($urandom);
      dir   = 2'($urandom % 3);
      step(s_n, op, !(dir == 2'd0), !(dir == 2'd1), 8'($urandom),
           ($urandom % 16) == 0, 14'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule